// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a single-clock synchronous static RAM of 32-bit words with a parameterised, small depth. An access is opened by one of two address strobes: the processor strobe, which takes priority, or the controller strobe. An access opens only if all three chip enables agree. The address presented at that edge is registered. A two-bit counter then steps through a four-word burst whenever the advance input is low. The burst order is linear or interleaved, chosen by a mode input.

Reads are flow-through. The word at the registered address reaches `dout` in the same cycle, with no output register. The bidirectional data bus is split into `din`, `dout` and a drive enable `dout_en`. Writes are either global, covering all four byte lanes, or per lane. A write on the controller strobe lands at the opening edge. On the processor strobe, the write inputs are ignored at the opening edge and act on later edges. The drive enable drops whenever write inputs are asserted, whatever the output enable says.

A sleep input moves a four-state power controller through RUN, DOZE, SLEEP and WAKE:
- RUN → DOZE when `zz` is sampled high.
- DOZE → SLEEP when `zz` is still high; DOZE → RUN when it has dropped.
- SLEEP → WAKE when `zz` is sampled low.
- WAKE → RUN when `zz` stays low; WAKE → SLEEP when it rises again.

Outside RUN, every other input is ignored, the bus is not driven, nothing is written, and any open access is abandoned. The stored contents are kept.

Top module: `fts_burst_ram`

## Requirements
- R1: An access opens at a clock edge only when a strobe is recognised and `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A recognised strobe with any other enable combination closes the current access, and `dout_en` stays low until a new access opens.
- R2: The processor strobe `adsp_n` is recognised only while `ce1_n` is low. When `adsp_n` is recognised, a low `adsc_n` in the same cycle is ignored. A low `adsp_n` with `ce1_n` high is not a strobe, so an open burst simply continues.
- R3: After the edge that registers address A, `dout` shows word A in that same cycle, before the next edge.
- R4: Each edge with `adv_n` low and no strobe advances the beat counter k by one (mod 4). The low two address bits are then start+k mod 4 when `burst_ilv`=0, and start XOR k when `burst_ilv`=1. The upper address bits do not change during a burst.
- R5: With `gw_n` low, a write stores all 32 bits, whatever `bwe_n` and `bw_n` are.
- R6: With `gw_n` high and `bwe_n` low, each low bit i of `bw_n` writes lane i (bits 8i+7:8i) and leaves the other lanes unchanged. With `bwe_n` high, nothing is written.
- R7: On an edge that opens an access via `adsp_n`, the write inputs are ignored. On later edges of that access with no strobe, asserted write inputs write `din` to the current burst address, and the counter then advances if `adv_n` is low.
- R8: On an edge that opens an access via `adsc_n` with `adsp_n` high, asserted write inputs write `din` to the address presented at that edge.
- R9: `dout_en` is high only while an access is open, `oe_n` is low, and no write input is asserted (`gw_n` low, or `bwe_n` low with any `bw_n` bit low). After reset it is low.
- R10: The first edge that samples `zz` high still serves the access at that edge. From then until RUN is re-entered, all inputs are ignored, `dout_en` is low and no write happens. Two consecutive high samples reach SLEEP; a single-cycle pulse returns to RUN at the next edge. Memory contents survive sleep.
- R11: From SLEEP, two consecutive low samples of `zz` return to RUN. No access is open then, so `dout_en` stays low until a new strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every synchronous input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| adsp_n | input | 1 | Processor address strobe, active low, gated by ce1_n |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Byte-lane selects, active low, bit i selects bits 8i+7:8i |
| oe_n | input | 1 | Output enable, active low, combinational |
| zz | input | 1 | Sleep request, active high |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | AW | Word address |
| din | input | 32 | Write data |
| dout | output | 32 | Flow-through read data |
| dout_en | output | 1 | Bus drive enable for dout |

## Verification
Two of the block's functions can land on the same edge:
- A continuation write together with a burst advance. The word must go to the old counter address, and the read that follows must come from the next one.
- A sleep request together with a live access. The access at the first `zz` edge must complete, while everything presented during DOZE and SLEEP, including write strobes aimed at a known word, must leave no trace.

Both are provoked by driving the inputs together in one cycle. They are judged by reading the affected words back through fresh accesses against the bench's arithmetic reference array.

// File: rtl/fts_pkg.sv
`timescale 1ns/1ps
package fts_pkg;
    typedef enum logic [1:0] {
        PWR_RUN   = 2'd0,
        PWR_DOZE  = 2'd1,
        PWR_SLEEP = 2'd2,
        PWR_WAKE  = 2'd3
    } pwr_state_t;
endpackage

// File: rtl/fts_pwr_fsm.sv
`timescale 1ns/1ps
module fts_pwr_fsm
    import fts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic zz,
    output logic run
);
    pwr_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_RUN;
        else        state_q <= state_d;
    end

    // next state: two samples in each direction
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_RUN:   if (zz)  state_d = PWR_DOZE;
            PWR_DOZE:  state_d = zz ? PWR_SLEEP : PWR_RUN;
            PWR_SLEEP: if (!zz) state_d = PWR_WAKE;
            PWR_WAKE:  state_d = zz ? PWR_SLEEP : PWR_RUN;
            default:   state_d = PWR_RUN;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            PWR_RUN: run = 1'b1;
            default: run = 1'b0;
        endcase
    end

    assert_enter_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_DOZE && zz) |=> (state_q == PWR_SLEEP));
    assert_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_WAKE && !zz) |=> run);
endmodule

// File: rtl/fts_burst_seq.sv
`timescale 1ns/1ps
module fts_burst_seq #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] seed,
    input  logic          step,
    input  logic          ilv,
    output logic [CW-1:0] cur
);
    logic [CW-1:0] seed_q, beat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seed_q <= '0;
            beat_q <= '0;
        end else if (load) begin
            seed_q <= seed;
            beat_q <= '0;
        end else if (step) begin
            beat_q <= beat_q + CW'(1);
        end
    end

    always_comb cur = ilv ? (seed_q ^ beat_q) : (seed_q + beat_q);

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (beat_q == $past(beat_q) + CW'(1)));
    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (beat_q == '0));
endmodule

// File: rtl/fts_lane_dec.sv
`timescale 1ns/1ps
module fts_lane_dec #(
    parameter int LANES = 4
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] sel_n,
    output logic [LANES-1:0] we
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign we[g] = !gw_n || (!bwe_n && !sel_n[g]);
    end
endmodule

// File: rtl/fts_store.sv
`timescale 1ns/1ps
module fts_store #(
    parameter int AW    = 6,
    parameter int LANES = 4,
    parameter int LW    = 8
) (
    input  logic                clk,
    input  logic [AW-1:0]       waddr,
    input  logic [LANES-1:0]    wmask,
    input  logic [LANES*LW-1:0] wdata,
    input  logic [AW-1:0]       raddr,
    output logic [LANES*LW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] cells [DEPTH];
        always_ff @(posedge clk) begin
            if (wmask[g]) cells[waddr] <= wdata[g*LW +: LW];
        end
        assign rdata[g*LW +: LW] = cells[raddr];
    end
endmodule

// File: rtl/fts_burst_ram.sv
`timescale 1ns/1ps
module fts_burst_ram #(
    parameter int AW    = 6,
    parameter int LANES = 4,
    parameter int LW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adsp_n,
    input  logic                adsc_n,
    input  logic                adv_n,
    input  logic                ce1_n,
    input  logic                ce2,
    input  logic                ce3_n,
    input  logic                gw_n,
    input  logic                bwe_n,
    input  logic [LANES-1:0]    bw_n,
    input  logic                oe_n,
    input  logic                zz,
    input  logic                burst_ilv,
    input  logic [AW-1:0]       addr,
    input  logic [LANES*LW-1:0] din,
    output logic [LANES*LW-1:0] dout,
    output logic                dout_en
);
    localparam int CW = 2;
    localparam int HW = AW - CW;

    logic             run;
    logic             p_seen, c_seen, strobe, selected;
    logic             start, c_write, cont, cont_write, step;
    logic [LANES-1:0] lane_we, wmask;
    logic             wr_any;
    logic             active_q;
    logic [HW-1:0]    hi_q;
    logic [CW-1:0]    cur;
    logic [AW-1:0]    waddr, raddr;

    fts_pwr_fsm u_pwr (
        .clk  (clk),
        .rst_n(rst_n),
        .zz   (zz),
        .run  (run)
    );

    fts_lane_dec #(.LANES(LANES)) u_dec (
        .gw_n (gw_n),
        .bwe_n(bwe_n),
        .sel_n(bw_n),
        .we   (lane_we)
    );

    // strobe recognition: processor strobe gated by ce1_n, and it wins
    always_comb begin
        p_seen     = !adsp_n && !ce1_n;
        c_seen     = !adsc_n && !p_seen;
        strobe     = p_seen || c_seen;
        selected   = !ce1_n && ce2 && !ce3_n;
        wr_any     = |lane_we;
        start      = run && strobe && selected;
        c_write    = start && c_seen && adsp_n && wr_any;
        cont       = run && !strobe && active_q;
        cont_write = cont && wr_any;
        step       = cont && !adv_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            hi_q     <= '0;
        end else if (!run) begin
            active_q <= 1'b0;
        end else if (strobe) begin
            active_q <= selected;
            if (selected) hi_q <= addr[AW-1:CW];
        end
    end

    fts_burst_seq #(.CW(CW)) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .load (start),
        .seed (addr[CW-1:0]),
        .step (step),
        .ilv  (burst_ilv),
        .cur  (cur)
    );

    always_comb begin
        raddr = {hi_q, cur};
        waddr = c_write ? addr : raddr;
        wmask = (c_write || cont_write) ? lane_we : '0;
    end

    fts_store #(.AW(AW), .LANES(LANES), .LW(LW)) u_store (
        .clk  (clk),
        .waddr(waddr),
        .wmask(wmask),
        .wdata(din),
        .raddr(raddr),
        .rdata(dout)
    );

    always_comb dout_en = run && active_q && !oe_n && !wr_any;

    assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> !oe_n);
    assert_write_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (gw_n && (bwe_n || (&bw_n))));
    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (wmask == '0));
    assert_gw_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !gw_n |-> (&lane_we));
    assert_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && strobe && !selected) |=> !dout_en);
    assert_hold_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || !strobe) |=> $stable(hi_q));
endmodule

// File: tb/fts_burst_ram_test.sv
`timescale 1ns/1ps
module fts_burst_ram_test;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n, adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n, gw_n, bwe_n, oe_n, zz, burst_ilv;
    logic [3:0]    bw_n;
    logic [AW-1:0] addr;
    logic [31:0]   din, dout;
    logic          dout_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] ref_mem [DEPTH];

    always #5 clk = ~clk;

    fts_burst_ram #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .oe_n(oe_n), .zz(zz), .burst_ilv(burst_ilv), .addr(addr),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [31:0] pat(int a);
        return 32'h9E3779B9 * 32'(a + 1) ^ 32'h5A5A0F0F;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        adsp_n = 1; adsc_n = 1; adv_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
        gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0; zz = 0;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic open_p(int a);
        idle(); adsp_n = 0; addr = AW'(a); tick(); idle(); #1;
    endtask

    task automatic open_c_read(int a);
        idle(); adsc_n = 0; addr = AW'(a); tick(); idle(); #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(); burst_ilv = 0; addr = '0; din = '0; rst_n = 0;
        tick(); tick();
        check("R9 reset drive", {31'b0, dout_en}, 32'd0);
        rst_n = 1; tick();

        // R8: fill through controller-strobe writes
        for (int a = 0; a < DEPTH; a++) begin
            idle(); adsc_n = 0; addr = AW'(a); gw_n = 0; din = pat(a); #1;
            check("R9 float on write", {31'b0, dout_en}, 32'd0);
            tick(); ref_mem[a] = pat(a); idle(); #1;
            check("R8 controller write", dout, pat(a));
            check("R3 drive after open", {31'b0, dout_en}, 32'd1);
        end

        // R3 / R4: full bursts in both orders from every start
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < DEPTH; a++) begin
                burst_ilv = m[0];
                open_p(a);
                check("R3 flow-through", dout, ref_mem[a]);
                for (int k = 1; k < 4; k++) begin
                    adv_n = 0; tick(); adv_n = 1; #1;
                    check("R4 burst order", dout,
                          ref_mem[(a & ~3) | (m == 1 ? ((a & 3) ^ k) : (((a & 3) + k) & 3))]);
                end
            end
        end
        burst_ilv = 0;

        // R7 / R6: processor open ignores writes, then byte writes
        for (int m = 0; m < 16; m++) begin
            int a;
            logic [31:0] nd;
            a = m * 4 + 1;
            idle(); adsp_n = 0; addr = AW'(a); gw_n = 0; din = 32'hDEADBEEF; tick();
            idle(); #1;
            check("R7 open ignores write", dout, ref_mem[a]);
            nd = ~ref_mem[a] ^ 32'(m * 32'h01010101);
            bwe_n = 0; bw_n = 4'(m); din = nd; #1;
            if (m != 15) check("R9 float on byte write", {31'b0, dout_en}, 32'd0);
            tick();
            for (int l = 0; l < 4; l++)
                if (!m[l]) ref_mem[a][l*8 +: 8] = nd[l*8 +: 8];
            idle(); #1;
            check("R6 byte lanes", dout, ref_mem[a]);
        end

        // R6: bwe_n high blocks byte selects
        open_p(2);
        bw_n = 4'h0; din = 32'h0; tick(); idle(); #1;
        check("R6 bwe_n high no write", dout, ref_mem[2]);

        // R5: global write ignores bwe_n/bw_n
        gw_n = 0; bwe_n = 1; bw_n = 4'hF; din = 32'h13572468; tick();
        ref_mem[2] = 32'h13572468; idle(); #1;
        check("R5 global write", dout, 32'h13572468);

        // R7 + R4 same edge: write current then advance
        open_p(8);
        for (int k = 0; k < 3; k++) begin
            gw_n = 0; adv_n = 0; din = 32'hC0DE0000 + 32'(k); tick();
            ref_mem[8 + k] = 32'hC0DE0000 + 32'(k); idle(); #1;
            check("R7 write then advance", dout, ref_mem[9 + k]);
        end
        open_c_read(8);
        check("R7 burst write readback", dout, ref_mem[8]);
        open_c_read(10);
        check("R7 burst write readback", dout, ref_mem[10]);

        // R2: processor strobe wins over controller strobe
        idle(); adsp_n = 0; adsc_n = 0; gw_n = 0; addr = 6'd20; din = 32'h0BADF00D; tick();
        idle(); #1;
        check("R2 priority no write", dout, ref_mem[20]);
        // R2: adsp_n with ce1_n high is no strobe, burst continues
        open_p(21);
        adsp_n = 0; ce1_n = 1; adv_n = 0; tick(); idle(); #1;
        check("R2 gated strobe continues", dout, ref_mem[22]);
        check("R2 still driven", {31'b0, dout_en}, 32'd1);

        // R1: all enable combinations
        for (int c = 0; c < 8; c++) begin
            open_p(31);
            {ce1_n, ce2, ce3_n} = 3'(c); adsc_n = 0; addr = 6'd30; tick(); idle(); #1;
            check("R1 select decode", {31'b0, dout_en}, (c == 2) ? 32'd1 : 32'd0);
            if (c == 2) check("R1 selected read", dout, ref_mem[30]);
        end

        // R9: output enable
        open_p(33);
        oe_n = 1; #1;
        check("R9 oe_n high", {31'b0, dout_en}, 32'd0);
        oe_n = 0; #1;
        check("R9 oe_n low", {31'b0, dout_en}, 32'd1);

        // R10 / R11: sleep cycle with ignored writes
        open_p(40);
        zz = 1; tick();
        check("R10 doze quiet", {31'b0, dout_en}, 32'd0);
        tick();
        for (int k = 0; k < 3; k++) begin
            adsc_n = 0; gw_n = 0; addr = 6'd40; din = 32'h0; tick();
            check("R10 asleep quiet", {31'b0, dout_en}, 32'd0);
        end
        idle(); tick();
        check("R11 wake quiet", {31'b0, dout_en}, 32'd0);
        tick();
        check("R11 no access after wake", {31'b0, dout_en}, 32'd0);
        open_p(40);
        check("R10 contents kept", dout, ref_mem[40]);
        check("R11 access after wake", {31'b0, dout_en}, 32'd1);

        // R10: first zz edge still serves its access; short pulse
        idle(); zz = 1; adsc_n = 0; gw_n = 0; addr = 6'd41; din = 32'h600DCAFE; tick();
        ref_mem[41] = 32'h600DCAFE;
        idle(); tick();
        open_p(41);
        check("R10 access at first zz edge", dout, 32'h600DCAFE);
        check("R10 short pulse back to run", {31'b0, dout_en}, 32'd1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule